// File: doc/BRIEF.md
# Configuration File Header Section Locator

This block reads the opening bytes of a device configuration file as they arrive on a byte stream. After a start pulse it confirms that the file opens with a fixed 13-byte signature. It then walks the typed sections that follow until it meets the section type that was requested, and reports that section's length. A downstream loader can then take the section's content straight from the same stream, because the block stops with the stream positioned on the first content byte of the section it found.

Each section consists of one type byte, a big-endian length, and then that many content bytes. Type 0x65 ('e') has a four-byte length and every other type has a two-byte length. The search fails if the signature is wrong, if a type byte is not a letter 'a' to 'e', or if a short-length section claims more than 255 bytes. It also fails once its byte budget after the signature is used up.

The controller has five states. ST_IDLE waits for a start. ST_PRE checks the signature bytes. ST_TYPE reads a section type. ST_LEN gathers the length bytes. ST_SKIP discards content bytes.

The transitions are as follows:
- ST_IDLE goes to ST_PRE on start.
- ST_PRE goes to ST_TYPE after the last signature byte, or to ST_IDLE on a mismatch.
- ST_TYPE goes to ST_LEN on a legal letter, or to ST_IDLE on an illegal letter or an exhausted budget.
- ST_LEN goes to ST_IDLE on a match or an oversize short length. On the last length byte of any other section it goes to ST_SKIP, or to ST_TYPE if the length is zero.
- ST_SKIP goes to ST_TYPE after the last content byte, or to ST_IDLE when the budget runs out.

Top module: `cfg_hdr_parser`

## Requirements
- R1: After reset, done_o, found_o, error_o and in_ready_o are low and length_o is zero.
- R2: start_i is taken only in ST_IDLE, which latches want_type_i. A start pulse during a search is ignored, and the search finishes as if it had not occurred.
- R3: The first 13 bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. At the first byte that differs, the search ends with error_o, and no byte after the differing one is consumed.
- R4: After the signature, each section is a type byte, a big-endian length and the content bytes. Type 0x65 takes four length bytes and types 0x61 to 0x64 take two.
- R5: A type byte below 0x61 or above 0x65 ends the search with error_o, right after that byte.
- R6: For a type other than 0x65, a length above 255 ends the search with error_o, even when the type matches the request.
- R7: When the type matches the request and the length is legal, the search ends with found_o and length_o equal to the section length. No content byte of that section is consumed. length_o keeps its value until the next successful search.
- R8: The content bytes of a non-matching section are consumed and discarded, and then the next type byte is read.
- R9: At most 100 bytes after the signature are counted. A type byte is read only while fewer than 100 have been consumed, and content skipping stops when the count reaches 100, which ends the search with error_o. Length bytes that follow an accepted type byte are always consumed.
- R10: Each search ends with done_o high for exactly one cycle, with exactly one of found_o and error_o high in that cycle. found_o and error_o are low in every other cycle.
- R11: A byte is consumed only in a cycle where in_valid_i and in_ready_o are both high. Gaps in in_valid_i only delay the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new search (taken only when idle) |
| want_type_i | input | 8 | Requested section type letter |
| in_valid_i | input | 1 | Stream byte present |
| in_data_i | input | 8 | Stream byte |
| in_ready_o | output | 1 | Block will consume the presented byte |
| done_o | output | 1 | One-cycle end-of-search pulse |
| found_o | output | 1 | Requested section located (with done_o) |
| error_o | output | 1 | Search failed (with done_o) |
| length_o | output | LEN_W | Length of the located section |

## Verification
The assertions check several properties on every cycle:
- done_o lasts a single cycle and is accompanied by exactly one of found_o or error_o.
- The stream is never accepted in the cycle of completion.
- A found short-length section never reports more than 255.
- The budget counter never rises more than four bytes past its limit.

Only the bench's scenarios can show three things. The first is that each search ends at the right byte count, whether it ends on a signature mismatch, an illegal letter, an oversize length or an exhausted budget. The second is that the reported length is correct for both length widths. The third is that stalls and stray start pulses leave the result unchanged.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int SIG_LEN = 13;

    localparam logic [7:0] TYPE_FIRST = 8'h61;
    localparam logic [7:0] TYPE_LAST  = 8'h65;
    localparam logic [7:0] TYPE_WIDE  = 8'h65;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_TYPE,
        ST_LEN,
        ST_SKIP
    } hdr_state_e;

    // Expected signature byte at position idx.
    function automatic logic [7:0] sig_byte(input logic [3:0] idx);
        logic [7:0] b;
        if (idx >= 4'd2 && idx <= 4'd9) begin
            b = idx[0] ? 8'hF0 : 8'h0F;
        end else if (idx == 4'd1) begin
            b = 8'h09;
        end else if (idx == 4'd12) begin
            b = 8'h01;
        end else begin
            b = 8'h00;
        end
        return b;
    endfunction

endpackage

// File: rtl/cfg_hdr_sig_check.sv
module cfg_hdr_sig_check
    import cfg_hdr_pkg::*;
(
    input  logic [3:0] idx_i,
    input  logic [7:0] byte_i,
    output logic       match_o,
    output logic       last_o
);
    always_comb begin
        match_o = (byte_i == sig_byte(idx_i));
        last_o  = (idx_i == 4'(SIG_LEN - 1));
    end
endmodule

// File: rtl/cfg_hdr_budget.sv
module cfg_hdr_budget #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic spent_o
);
    localparam int CW = $clog2(LIMIT + 5);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign spent_o = (cnt_q >= CW'(LIMIT));

    // A type byte enters below the limit; at most four length bytes follow it.
    assert_budget_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT + 4));
endmodule

// File: rtl/cfg_hdr_len_acc.sv
module cfg_hdr_len_acc #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic [7:0]       byte_i,
    output logic [LEN_W-1:0] next_o
);
    localparam int HOLD_W = LEN_W - 8;

    logic [HOLD_W-1:0] acc_q;

    assign next_o = {acc_q, byte_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr_i) begin
            acc_q <= '0;
        end else if (shift_i) begin
            acc_q <= next_o[HOLD_W-1:0];
        end
    end
endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser
    import cfg_hdr_pkg::*;
#(
    parameter int BYTE_BUDGET   = 100,
    parameter int SHORT_LEN_MAX = 255,
    parameter int LEN_W         = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       want_type_i,
    input  logic             in_valid_i,
    input  logic [7:0]       in_data_i,
    output logic             in_ready_o,
    output logic             done_o,
    output logic             found_o,
    output logic             error_o,
    output logic [LEN_W-1:0] length_o
);
    hdr_state_e state_q, state_d;

    logic [7:0]       want_q;
    logic [3:0]       sig_idx_q;
    logic [7:0]       type_q;
    logic             wide_q;
    logic [1:0]       len_idx_q;
    logic [LEN_W-1:0] skip_rem_q;

    logic             take;
    logic             begin_search;
    logic             sig_match, sig_last;
    logic             budget_spent;
    logic [LEN_W-1:0] len_full;
    logic             len_last;
    logic             fin_found, fin_fail;

    assign begin_search = start_i && (state_q == ST_IDLE);
    assign take         = in_valid_i && in_ready_o;
    assign len_last     = (len_idx_q == (wide_q ? 2'd3 : 2'd1));

    cfg_hdr_sig_check sig_i (
        .idx_i   (sig_idx_q),
        .byte_i  (in_data_i),
        .match_o (sig_match),
        .last_o  (sig_last)
    );

    cfg_hdr_budget #(.LIMIT(BYTE_BUDGET)) budget_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (begin_search),
        .inc_i   (take && (state_q != ST_PRE)),
        .spent_o (budget_spent)
    );

    cfg_hdr_len_acc #(.LEN_W(LEN_W)) len_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (take && (state_q == ST_TYPE)),
        .shift_i (take && (state_q == ST_LEN)),
        .byte_i  (in_data_i),
        .next_o  (len_full)
    );

    // Ready depends on state only, never on in_valid_i.
    always_comb begin
        unique case (state_q)
            ST_PRE, ST_LEN:  in_ready_o = 1'b1;
            ST_TYPE, ST_SKIP: in_ready_o = !budget_spent;
            default:          in_ready_o = 1'b0;
        endcase
    end

    // Next state and end-of-search events.
    always_comb begin
        state_d   = state_q;
        fin_found = 1'b0;
        fin_fail  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_PRE;
            end
            ST_PRE: begin
                if (take) begin
                    if (!sig_match) begin
                        fin_fail = 1'b1;
                        state_d  = ST_IDLE;
                    end else if (sig_last) begin
                        state_d = ST_TYPE;
                    end
                end
            end
            ST_TYPE: begin
                if (budget_spent) begin
                    fin_fail = 1'b1;
                    state_d  = ST_IDLE;
                end else if (take) begin
                    if (in_data_i < TYPE_FIRST || in_data_i > TYPE_LAST) begin
                        fin_fail = 1'b1;
                        state_d  = ST_IDLE;
                    end else begin
                        state_d = ST_LEN;
                    end
                end
            end
            ST_LEN: begin
                if (take && len_last) begin
                    if (!wide_q && len_full > LEN_W'(SHORT_LEN_MAX)) begin
                        fin_fail = 1'b1;
                        state_d  = ST_IDLE;
                    end else if (type_q == want_q) begin
                        fin_found = 1'b1;
                        state_d   = ST_IDLE;
                    end else if (len_full == '0) begin
                        state_d = ST_TYPE;
                    end else begin
                        state_d = ST_SKIP;
                    end
                end
            end
            ST_SKIP: begin
                if (budget_spent) begin
                    fin_fail = 1'b1;
                    state_d  = ST_IDLE;
                end else if (take && skip_rem_q == LEN_W'(1)) begin
                    state_d = ST_TYPE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Search bookkeeping registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            want_q     <= '0;
            sig_idx_q  <= '0;
            type_q     <= '0;
            wide_q     <= 1'b0;
            len_idx_q  <= '0;
            skip_rem_q <= '0;
        end else begin
            if (begin_search) begin
                want_q    <= want_type_i;
                sig_idx_q <= '0;
            end
            if (take && state_q == ST_PRE) begin
                sig_idx_q <= sig_idx_q + 4'd1;
            end
            if (take && state_q == ST_TYPE) begin
                type_q    <= in_data_i;
                wide_q    <= (in_data_i == TYPE_WIDE);
                len_idx_q <= '0;
            end
            if (take && state_q == ST_LEN) begin
                len_idx_q <= len_idx_q + 2'd1;
                if (len_last) skip_rem_q <= len_full;
            end
            if (take && state_q == ST_SKIP) begin
                skip_rem_q <= skip_rem_q - LEN_W'(1);
            end
        end
    end

    // Registered outcome.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            found_o  <= 1'b0;
            error_o  <= 1'b0;
            length_o <= '0;
        end else begin
            done_o  <= fin_found || fin_fail;
            found_o <= fin_found;
            error_o <= fin_fail;
            if (fin_found) length_o <= len_full;
        end
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (found_o ^ error_o));

    assert_flags_need_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (found_o || error_o) |-> done_o);

    assert_no_take_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !in_ready_o);

    assert_short_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (found_o && want_q != TYPE_WIDE) |-> (length_o <= LEN_W'(SHORT_LEN_MAX)));

endmodule

// File: tb/cfg_hdr_parser_tb.sv
module cfg_hdr_parser_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] SIG [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0,
                                        8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  want_type_i = 8'h00;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_data_i = 8'h00;
    logic        in_ready_o, done_o, found_o, error_o;
    logic [31:0] length_o;

    int vectors = 0;
    int errs = 0;
    int cycles = 0;
    logic [7:0]  strm [256];
    int wp;
    logic [31:0] last_len = 32'd0;

    cfg_hdr_parser dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .want_type_i(want_type_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
        .done_o(done_o), .found_o(found_o), .error_o(error_o), .length_o(length_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wrap_up();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errs++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            wrap_up();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic new_stream();
        for (int i = 0; i < 256; i++) strm[i] = 8'hEE;
        for (int k = 0; k < 13; k++) strm[k] = SIG[k];
        wp = 13;
    endtask

    task automatic put(input logic [7:0] b);
        if (wp < 256) strm[wp] = b;
        wp++;
    endtask

    task automatic add_sec(input logic [7:0] t, input logic [31:0] len);
        put(t);
        if (t == 8'h65) begin
            put(len[31:24]);
            put(len[23:16]);
        end
        put(len[15:8]);
        put(len[7:0]);
        for (int i = 0; i < ((len < 32'd120) ? int'(len) : 120); i++) put(8'h5A);
    endtask

    // Reference model written from the requirements.
    task automatic model(input logic [7:0] want, output bit e_found,
                         output logic [31:0] e_len, output int e_used);
        int pos, cnt, nl;
        logic [7:0]  t;
        logic [31:0] l;
        e_found = 1'b0;
        e_len   = 32'd0;
        for (int k = 0; k < 13; k++) begin
            if (strm[k] != SIG[k]) begin
                e_used = k + 1;
                return;
            end
        end
        pos = 13;
        cnt = 0;
        forever begin
            if (cnt >= 100) begin e_used = pos; return; end
            t = strm[pos]; pos++; cnt++;
            if (t < 8'h61 || t > 8'h65) begin e_used = pos; return; end
            nl = (t == 8'h65) ? 4 : 2;
            l = 32'd0;
            for (int j = 0; j < nl; j++) begin
                l = {l[23:0], strm[pos]};
                pos++; cnt++;
            end
            if (t != 8'h65 && l > 32'd255) begin e_used = pos; return; end
            if (t == want) begin e_found = 1'b1; e_len = l; e_used = pos; return; end
            while (l > 0 && cnt < 100) begin pos++; cnt++; l--; end
        end
    endtask

    task automatic run_case(input string req, input logic [7:0] want,
                            input bit stall, input bit poke);
        bit          e_found, got, a_found, a_err, a_rdy, after;
        logic [31:0] e_len, a_len;
        int          e_used, ptr, cyc;
        model(want, e_found, e_len, e_used);
        @(negedge clk);
        want_type_i = want;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        ptr = 0; cyc = 0; got = 1'b0;
        a_found = 0; a_err = 0; a_rdy = 0; a_len = 0;
        while (!got && cyc < 3000) begin
            if (done_o) begin
                got = 1'b1;
                a_found = found_o; a_err = error_o; a_len = length_o; a_rdy = in_ready_o;
            end else begin
                in_valid_i = !stall || cyc[0];
                in_data_i  = strm[ptr];
                start_i    = poke && (ptr == 20);
                if (in_valid_i && in_ready_o) ptr++;
                @(negedge clk);
                cyc++;
            end
        end
        in_valid_i = 1'b0;
        start_i = 1'b0;
        @(negedge clk);
        after = done_o;
        vectors++;
        chk({req, " done seen"}, 32'(got), 32'd1);
        chk({req, " found"}, 32'(a_found), 32'(e_found));
        chk({req, " error"}, 32'(a_err), 32'(!e_found));
        chk({req, " bytes consumed"}, 32'(ptr), 32'(e_used));
        chk({req, " length"}, a_len, e_found ? e_len : last_len);
        chk({req, " ready at end R7"}, 32'(a_rdy), 32'd0);
        chk({req, " done one cycle R10"}, 32'(after), 32'd0);
        chk({req, " flags clear after R10"}, 32'(found_o || error_o), 32'd0);
        if (e_found) last_len = e_len;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        chk("R1 done", 32'(done_o), 32'd0);
        chk("R1 found", 32'(found_o), 32'd0);
        chk("R1 error", 32'(error_o), 32'd0);
        chk("R1 ready", 32'(in_ready_o), 32'd0);
        chk("R1 length", length_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: clean signature, then a flipped byte at each position
        new_stream(); add_sec(8'h61, 32'd1);
        run_case("R3 clean", 8'h61, 1'b0, 1'b0);
        for (int p = 0; p < 13; p++) begin
            new_stream(); add_sec(8'h61, 32'd1);
            strm[p] = strm[p] ^ 8'h40;
            run_case("R3 mismatch", 8'h61, 1'b0, 1'b0);
        end

        // R5: sweep of type bytes around the legal range
        for (int t = 8'h5C; t <= 8'h68; t++) begin
            new_stream(); add_sec(8'(t), 32'd3); add_sec(8'h63, 32'd5);
            run_case("R5 type sweep", 8'h63, 1'b0, 1'b0);
        end

        // R4 / R7 / R8: each letter requested from one chain, plain, stalled (R11), poked (R2)
        for (int w = 8'h61; w <= 8'h66; w++) begin
            for (int v = 0; v < 3; v++) begin
                new_stream();
                add_sec(8'h61, 32'd4); add_sec(8'h62, 32'd0); add_sec(8'h63, 32'd7);
                add_sec(8'h64, 32'd2); add_sec(8'h65, 32'h0000_0009);
                run_case(v == 0 ? "R4 R7 R8 chain" : (v == 1 ? "R11 stalled" : "R2 stray start"),
                         8'(w), v == 1, v == 2);
            end
        end

        // R6: short-length limit
        new_stream(); add_sec(8'h62, 32'd256);
        run_case("R6 short 256 match", 8'h62, 1'b0, 1'b0);
        new_stream(); add_sec(8'h62, 32'd255);
        run_case("R6 short 255 match", 8'h62, 1'b0, 1'b0);
        new_stream(); add_sec(8'h61, 32'h1FF); add_sec(8'h63, 32'd1);
        run_case("R6 short oversize skip", 8'h63, 1'b0, 1'b0);
        new_stream(); add_sec(8'h65, 32'h0102_0304);
        run_case("R4 wide length", 8'h65, 1'b0, 1'b0);

        // R9: budget sweep over the first section's size
        for (int l = 0; l <= 112; l++) begin
            new_stream(); add_sec(8'h61, 32'(l)); add_sec(8'h64, 32'd7);
            run_case("R9 budget sweep", 8'h64, 1'b0, 1'b0);
        end
        // R9: chains of empty sections
        for (int n = 30; n <= 35; n++) begin
            new_stream();
            for (int i = 0; i < n; i++) add_sec(8'h62, 32'd0);
            add_sec(8'h63, 32'd1);
            run_case("R9 empty chain", 8'h63, 1'b0, 1'b0);
        end
        // R9: wide length bytes cross the budget after an accepted type
        new_stream(); add_sec(8'h61, 32'd94); add_sec(8'h65, 32'd5);
        run_case("R9 wide crossing", 8'h65, 1'b0, 1'b0);

        wrap_up();
    end

endmodule